// File: doc/BRIEF.md
# Host Controller Save/Restore Status Register

This block holds the 32-bit status word of a USB host controller as seen on its memory-mapped register space. It reports whether the controller is halted, whether an internal state save or state restore is under way, and whether the last such operation failed. Software reads the word through a simple read strobe and address. It may write the word at any time, but a write can only clear the error flag. Every other bit is either read-only or always zero.

A command decoder elsewhere pulses `cmd_save` or `cmd_restore` when software sets the matching bit in the command register. The save/restore engine reports completion on `eng_save_done` or `eng_restore_done`, and reports a failure on `eng_error`. A three-state machine tracks the engine. In `ST_IDLE`, an accepted save command takes the transition *begin-save* to `ST_SAVING`. Otherwise an accepted restore command takes *begin-restore* to `ST_RESTORING`. From `ST_SAVING`, *save-complete* returns to `ST_IDLE` when `eng_save_done` is seen. From `ST_RESTORING`, *restore-complete* returns to `ST_IDLE` when `eng_restore_done` is seen. Every other case holds the current state.

The error flag is kept by a two-state machine. *err-raise* moves it from `ERR_CLEAR` to `ERR_SET`. *err-clear* moves it back, either on a software write of 1 to the flag or when a new operation is accepted.

Top module: `hc_status_reg`

## Requirements
- R1: After reset the register reads 0x00000001. The halted flag is 1, and the save-busy, restore-busy and error flags are 0.
- R2: Every bit other than 0, 8, 9 and 10 reads as 0. A write of any value leaves those bits at 0.
- R3: Bit 0 (halted) copies `halted_in` one clock later. Register writes do not change it.
- R4: A save command accepted in idle sets bit 8 (save busy) on the next clock. Bit 8 stays 1 until `eng_save_done` is seen, and it reads 0 from the clock after that.
- R5: A restore command accepted in idle sets bit 9 (restore busy) on the next clock. Bit 9 stays 1 until `eng_restore_done` is seen, and it reads 0 from the clock after that.
- R6: Commands that arrive while bit 8 or bit 9 is 1 are ignored, and so are done signals for the operation that is not running. Bits 8 and 9 are never 1 together. If both commands arrive together in idle, the save is started.
- R7: Software writes never change bits 8 and 9.
- R8: `eng_error` while an operation is in progress sets bit 10 (save/restore error) on the next clock. The flag stays set after the operation ends. `eng_error` in idle is ignored.
- R9: Writing 1 to bit 10 at the register offset clears it. Writing 0 to bit 10 leaves it unchanged.
- R10: Accepting a new save or restore clears bit 10, and this takes precedence over a simultaneous `eng_error`. If `eng_error` during an operation coincides with a write-1-to-clear, bit 10 ends up set.
- R11: With `reg_rd` high and `reg_addr` equal to the register offset, `rd_data` shows the current flags in the same cycle. Otherwise `rd_data` is 0. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| cmd_save | input | 1 | Pulse: save-state command written |
| cmd_restore | input | 1 | Pulse: restore-state command written |
| eng_save_done | input | 1 | Engine finished a save |
| eng_restore_done | input | 1 | Engine finished a restore |
| eng_error | input | 1 | Engine reports a save/restore failure |
| halted_in | input | 1 | Run/stop status from the controller core |
| rd_data | output | 32 | Read value of the status word |
| halted | output | 1 | Halted flag (bit 0) |
| save_busy | output | 1 | Save in progress (bit 8) |
| restore_busy | output | 1 | Restore in progress (bit 9) |
| sr_error | output | 1 | Sticky save/restore error (bit 10) |

## Verification
The properties assume three things about the surrounding logic. Command and engine inputs are 0/1 levels sampled once per clock. A done pulse is meaningful only while its own operation is in progress. A write clears the error flag only when it targets the register offset. The stimulus therefore drives at most one event of each kind per clock. It also deliberately sends stray done pulses, stray commands and idle-time errors, to show that the design ignores them rather than relying on the environment to avoid them. The coincidence cases (error with start, error with clear, both commands together) are each placed into a single clock on purpose.

// File: rtl/hcsts_pkg.sv
package hcsts_pkg;
    localparam int REG_W     = 32;
    localparam int BIT_HALT  = 0;
    localparam int BIT_SAVE  = 8;
    localparam int BIT_REST  = 9;
    localparam int BIT_ERR   = 10;
    localparam int BIT_NRDY  = 11;
    localparam int BIT_HCERR = 12;
    localparam logic [REG_W-1:0] RESET_VALUE = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SAVING    = 2'd1,
        ST_RESTORING = 2'd2
    } sr_state_e;

    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_SET   = 1'b1
    } err_state_e;

    typedef struct packed {
        logic err;
        logic rest;
        logic save;
        logic halt;
    } sts_flags_t;
endpackage

// File: rtl/hcsts_busy_fsm.sv
module hcsts_busy_fsm
    import hcsts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_save,
    input  logic cmd_restore,
    input  logic save_done,
    input  logic restore_done,
    output logic save_busy,
    output logic restore_busy,
    output logic start_accept
);
    sr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: begin-save, begin-restore, save-complete, restore-complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_save)         state_d = ST_SAVING;
                else if (cmd_restore) state_d = ST_RESTORING;
            end
            ST_SAVING: begin
                if (save_done) state_d = ST_IDLE;
            end
            ST_RESTORING: begin
                if (restore_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        save_busy    = 1'b0;
        restore_busy = 1'b0;
        start_accept = 1'b0;
        unique case (state_q)
            ST_IDLE:      start_accept = cmd_save | cmd_restore;
            ST_SAVING:    save_busy    = 1'b1;
            ST_RESTORING: restore_busy = 1'b1;
            default:      start_accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/hcsts_err_flag.sv
module hcsts_err_flag
    import hcsts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    input  logic eng_error,
    input  logic sw_clear,
    output logic err
);
    err_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ERR_CLEAR;
        else        st_q <= st_d;
    end

    // A new start dominates; an engine error beats a software clear.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ERR_CLEAR: begin
                if (!start && busy && eng_error) st_d = ERR_SET;
            end
            ERR_SET: begin
                if (start)                          st_d = ERR_CLEAR;
                else if (sw_clear && !(busy && eng_error)) st_d = ERR_CLEAR;
            end
            default: st_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        err = (st_q == ERR_SET);
    end
endmodule

// File: rtl/hcsts_read_mux.sv
module hcsts_read_mux
    import hcsts_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = '0
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  sts_flags_t        flags,
    output logic [REG_W-1:0]  data
);
    logic [REG_W-1:0] word;
    logic             hit;

    // Build the word bit by bit; unlisted positions are constant zero.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == BIT_HALT) begin : g_halt
            assign word[i] = flags.halt;
        end else if (i == BIT_SAVE) begin : g_save
            assign word[i] = flags.save;
        end else if (i == BIT_REST) begin : g_rest
            assign word[i] = flags.rest;
        end else if (i == BIT_ERR) begin : g_err
            assign word[i] = flags.err;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end

    assign hit  = rd && (addr == OFFSET);
    assign data = hit ? word : '0;
endmodule

// File: rtl/hc_status_reg.sv
module hc_status_reg
    import hcsts_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] STS_OFFSET = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              cmd_save,
    input  logic              cmd_restore,
    input  logic              eng_save_done,
    input  logic              eng_restore_done,
    input  logic              eng_error,
    input  logic              halted_in,
    output logic [31:0]       rd_data,
    output logic              halted,
    output logic              save_busy,
    output logic              restore_busy,
    output logic              sr_error
);
    logic       halt_q;
    logic       start_accept;
    logic       sw_clear;
    logic       wdata_unused;
    sts_flags_t flags;

    // Bits other than the error flag carry no write effect.
    assign wdata_unused = ^{reg_wdata[REG_W-1:BIT_ERR+1], reg_wdata[BIT_ERR-1:0]};
    assign sw_clear     = reg_wr && (reg_addr == STS_OFFSET) && reg_wdata[BIT_ERR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_q <= RESET_VALUE[BIT_HALT];
        else        halt_q <= halted_in;
    end

    hcsts_busy_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_save     (cmd_save),
        .cmd_restore  (cmd_restore),
        .save_done    (eng_save_done),
        .restore_done (eng_restore_done),
        .save_busy    (save_busy),
        .restore_busy (restore_busy),
        .start_accept (start_accept)
    );

    hcsts_err_flag u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_accept),
        .busy      (save_busy | restore_busy),
        .eng_error (eng_error),
        .sw_clear  (sw_clear),
        .err       (sr_error)
    );

    assign halted = halt_q;
    assign flags  = '{err: sr_error, rest: restore_busy, save: save_busy, halt: halt_q};

    hcsts_read_mux #(
        .ADDR_W (ADDR_W),
        .OFFSET (STS_OFFSET)
    ) u_rd (
        .rd    (reg_rd),
        .addr  (reg_addr),
        .flags (flags),
        .data  (rd_data)
    );
endmodule

// File: rtl/hcsts_checker.sv
module hcsts_checker #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] STS_OFFSET = 12'h004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              cmd_save,
    input logic              cmd_restore,
    input logic              eng_save_done,
    input logic              eng_restore_done,
    input logic              eng_error,
    input logic              halted_in,
    input logic [31:0]       rd_data,
    input logic              halted,
    input logic              save_busy,
    input logic              restore_busy,
    input logic              sr_error
);
    logic idle, busy, hit_wr1;
    assign idle    = !save_busy && !restore_busy;
    assign busy    = !idle;
    assign hit_wr1 = reg_wr && (reg_addr == STS_OFFSET) && reg_wdata[10];

    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (rd_data[31:11] == '0 && rd_data[7:1] == '0));

    p_halt_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> halted == $past(halted_in));

    p_save_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_save) |=> save_busy);

    p_save_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_busy && !eng_save_done) |=> save_busy);

    p_save_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_busy && eng_save_done) |=> !save_busy);

    p_rest_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !cmd_save && cmd_restore) |=> restore_busy);

    p_rest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_busy && !eng_restore_done) |=> restore_busy);

    p_one_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({save_busy, restore_busy}) <= 1);

    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_error) |=> sr_error);

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !cmd_save && !cmd_restore && !hit_wr1) |=> (sr_error == $past(sr_error)));

    p_err_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr1 && !(busy && eng_error)) |=> !sr_error);

    p_err_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (cmd_save || cmd_restore)) |=> !sr_error);

    p_rd_view_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == STS_OFFSET) |->
            (rd_data[0] == halted && rd_data[8] == save_busy &&
             rd_data[9] == restore_busy && rd_data[10] == sr_error));

    p_rd_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == STS_OFFSET) |-> rd_data == '0);
endmodule

bind hc_status_reg hcsts_checker #(
    .ADDR_W     (ADDR_W),
    .STS_OFFSET (STS_OFFSET)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_rd           (reg_rd),
    .reg_wr           (reg_wr),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .cmd_save         (cmd_save),
    .cmd_restore      (cmd_restore),
    .eng_save_done    (eng_save_done),
    .eng_restore_done (eng_restore_done),
    .eng_error        (eng_error),
    .halted_in        (halted_in),
    .rd_data          (rd_data),
    .halted           (halted),
    .save_busy        (save_busy),
    .restore_busy     (restore_busy),
    .sr_error         (sr_error)
);

// File: tb/sim_hc_status_reg.sv
`timescale 1ns/1ps
module sim_hc_status_reg;
    localparam int AW = 12;
    localparam logic [AW-1:0] OFF = 12'h004;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_rd = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          cmd_save = 1'b0, cmd_restore = 1'b0;
    logic          eng_save_done = 1'b0, eng_restore_done = 1'b0, eng_error = 1'b0;
    logic          halted_in = 1'b1;
    logic [31:0]   rd_data;
    logic          halted, save_busy, restore_busy, sr_error;

    int n_checks = 0;
    int n_errs   = 0;

    always #5 clk = ~clk;

    hc_status_reg #(.ADDR_W(AW), .STS_OFFSET(OFF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cmd_save(cmd_save), .cmd_restore(cmd_restore),
        .eng_save_done(eng_save_done), .eng_restore_done(eng_restore_done),
        .eng_error(eng_error), .halted_in(halted_in),
        .rd_data(rd_data), .halted(halted), .save_busy(save_busy),
        .restore_busy(restore_busy), .sr_error(sr_error)
    );

    // Behavioural reference: plain bits updated once per clock from the requirements.
    bit m_halt, m_sb, m_rb, m_err;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_halt <= 1'b1; m_sb <= 1'b0; m_rb <= 1'b0; m_err <= 1'b0;
        end else begin
            bit idle_now, go, w1c;
            idle_now = !m_sb && !m_rb;
            go  = idle_now && (cmd_save || cmd_restore);
            w1c = reg_wr && reg_addr == OFF && reg_wdata[10];
            m_halt <= halted_in;
            if (go) m_err <= 1'b0;
            else if (!idle_now && eng_error) m_err <= 1'b1;
            else if (w1c) m_err <= 1'b0;
            if (idle_now) begin
                m_sb <= cmd_save;
                m_rb <= !cmd_save && cmd_restore;
            end else begin
                if (m_sb && eng_save_done)    m_sb <= 1'b0;
                if (m_rb && eng_restore_done) m_rb <= 1'b0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] exp_rd;
            exp_rd = (reg_rd && reg_addr == OFF)
                   ? {21'd0, m_err, m_rb, m_sb, 7'd0, m_halt} : 32'd0;
            check("R3 halted",      {31'd0, halted},       {31'd0, m_halt});
            check("R4 save_busy",   {31'd0, save_busy},    {31'd0, m_sb});
            check("R5 restore_busy",{31'd0, restore_busy}, {31'd0, m_rb});
            check("R8 sr_error",    {31'd0, sr_error},     {31'd0, m_err});
            check("R11 rd_data",    rd_data,               exp_rd);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_chk(input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = OFF;
        #1;
        check(tag, rd_data, exp);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = '0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset value
        rd_chk(32'h0000_0001, "R1 reset word");
        check("R1 flags", {28'd0, sr_error, restore_busy, save_busy, halted}, 32'h1);

        // R2: writes cannot set fixed bits
        wr(OFF, 32'hFFFF_FFFF);
        rd_chk(32'h0000_0001, "R2 after all-ones write");
        reg_rd = 1'b1; reg_addr = OFF + 12'h4; #1;
        check("R11 other address", rd_data, 32'h0);
        reg_rd = 1'b0;

        // R3: halted follows input, ignores writes
        halted_in = 1'b0; step();
        rd_chk(32'h0000_0000, "R3 halted low");
        wr(OFF, 32'h0000_0001);
        rd_chk(32'h0000_0000, "R3 write ignored");
        halted_in = 1'b1; step();

        // R4: save busy
        cmd_save = 1'b1; step(); cmd_save = 1'b0;
        check("R4 set", {31'd0, save_busy}, 32'd1);
        repeat (3) step();
        rd_chk(32'h0000_0101, "R4 held");

        // R6: commands and stray done while busy
        cmd_restore = 1'b1; step(); cmd_restore = 1'b0;
        check("R6 restore ignored", {31'd0, restore_busy}, 32'd0);
        cmd_save = 1'b1; eng_restore_done = 1'b1; step();
        cmd_save = 1'b0; eng_restore_done = 1'b0;
        check("R6 stray done", {31'd0, save_busy}, 32'd1);

        // R7: writes do not disturb busy flags
        wr(OFF, 32'hFFFF_FFFF);
        rd_chk(32'h0000_0101, "R7 busy kept");

        // R8: error during save, sticky afterwards
        eng_error = 1'b1; step(); eng_error = 1'b0;
        check("R8 set", {31'd0, sr_error}, 32'd1);
        eng_save_done = 1'b1; step(); eng_save_done = 1'b0;
        check("R4 cleared", {31'd0, save_busy}, 32'd0);
        rd_chk(32'h0000_0401, "R8 sticky");

        // R9: write-one-to-clear
        wr(OFF, 32'hFFFF_FBFF);
        check("R9 zero write keeps", {31'd0, sr_error}, 32'd1);
        wr(OFF + 12'h8, 32'h0000_0400);
        check("R9 other address keeps", {31'd0, sr_error}, 32'd1);
        wr(OFF, 32'h0000_0400);
        check("R9 cleared", {31'd0, sr_error}, 32'd0);
        eng_error = 1'b1; step(); eng_error = 1'b0;
        check("R8 idle error ignored", {31'd0, sr_error}, 32'd0);

        // R5 and R10
        cmd_restore = 1'b1; step(); cmd_restore = 1'b0;
        rd_chk(32'h0000_0201, "R5 restore busy");
        eng_error = 1'b1; step(); eng_error = 1'b0;
        eng_restore_done = 1'b1; step(); eng_restore_done = 1'b0;
        check("R5 cleared", {31'd0, restore_busy}, 32'd0);
        check("R8 kept", {31'd0, sr_error}, 32'd1);
        cmd_save = 1'b1; step(); cmd_save = 1'b0;
        check("R10 start clears", {31'd0, sr_error}, 32'd0);
        eng_error = 1'b1; reg_wr = 1'b1; reg_addr = OFF; reg_wdata = 32'h400;
        step();
        eng_error = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R10 error beats clear", {31'd0, sr_error}, 32'd1);
        eng_save_done = 1'b1; step(); eng_save_done = 1'b0;
        cmd_restore = 1'b1; eng_error = 1'b1; step();
        cmd_restore = 1'b0; eng_error = 1'b0;
        check("R10 start beats error", {31'd0, sr_error}, 32'd0);
        check("R5 started", {31'd0, restore_busy}, 32'd1);
        eng_restore_done = 1'b1; step(); eng_restore_done = 1'b0;

        // R6: both commands together in idle
        cmd_save = 1'b1; cmd_restore = 1'b1; step();
        cmd_save = 1'b0; cmd_restore = 1'b0;
        check("R6 save wins", {30'd0, restore_busy, save_busy}, 32'd1);
        eng_save_done = 1'b1; step(); eng_save_done = 1'b0;
        step();

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule